// File: doc/BRIEF.md
# Non-Restoring Single-Step Divider

This block performs one step of non-restoring binary division per enabled clock, the step that software repeats to build a full 32/32 unsigned or signed divide. It holds a partial remainder, a divisor, and three flag bits: the running quotient-sign bit `q`, the divisor-sign bit `m`, and the carry/link bit `t`. Each step shifts the remainder left by one and inserts `t` at the bottom. It then adds or subtracts the divisor, depending on whether the old `q` agrees with `m`. The new `q` comes from the XOR of the remainder's pre-shift top bit, the adder's carry or borrow, and `m`. The new `t` reports whether that new `q` equals `m`.

A small sequencer around the step loads the operands and flags on `start` and then runs a programmed number of steps, one per cycle in which `step_en` is high. It raises `done` when the last step has run. In chained mode a second register, the dividend/quotient register, feeds its top bit in as `t` on every step and shifts the resulting `t` in at its bottom. After 32 steps from all-zero flags and a zero remainder, this register holds the unsigned quotient. The flag set-up step and any remainder correction are not part of this block.

Top module: `nrdiv_unit`

## Requirements
- R1: In a step the new remainder is `{rem[W-2:0], tin}` minus the divisor when the old `q` equals `m`, and that value plus the divisor otherwise. Here `tin` is the incoming link bit and the arithmetic is modulo 2^W.
- R2: Let `cf` be the borrow of that subtraction, or the carry-out of that addition. The new `q` is `rem[W-1] ^ cf ^ m`, where `rem[W-1]` is taken before the shift. For a subtraction with `m`=0, the new `q` is the borrow if the old top bit was 0 and its inverse if it was 1. The three other cases mirror this rule.
- R3: The new `t` is 1 exactly when the new `q` equals `m`.
- R4: A `start` pulse loads the remainder, the dividend/quotient register, the divisor, `q`, `m`, `t`, the mode and the step count in the next cycle. `busy` then stays high until exactly `step_count` enabled steps have run. `done` rises with the last step and stays high until the next `start`. A count of 0 sets `done` at once. `busy` and `done` are never high together.
- R5: While `busy` is high and `step_en` is low, the remainder, the dividend/quotient register, `q` and `t` keep their values.
- R6: With `chain`=0, `tin` is the stored `t` and the dividend/quotient register is left unchanged. With `chain`=1, `tin` is `dq[W-1]` and the register becomes `{dq[W-2:0], new t}`.
- R7: With `chain`=1, the remainder at 0, `q`=`m`=`t`=0, `dq` set to the dividend and W steps, `dq_out` ends as the unsigned quotient floor(dividend/divisor) for any non-zero divisor.
- R8: After reset, `busy`, `done`, `rem_out`, `dq_out`, `q_out` and `t_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load operands and begin a run |
| chain | input | 1 | 1: link bit comes from and returns to the dividend/quotient register |
| step_en | input | 1 | Clock enable for steps |
| step_count | input | CW | Number of steps to run (CW = clog2(MAX_STEPS+1)) |
| init_rem | input | W | Initial partial remainder |
| init_dq | input | W | Initial dividend/quotient register |
| divisor | input | W | Divisor |
| init_q | input | 1 | Initial q flag |
| init_m | input | 1 | Divisor sign flag |
| init_t | input | 1 | Initial link bit |
| busy | output | 1 | Steps still to run |
| done | output | 1 | Programmed steps complete |
| rem_out | output | W | Partial remainder |
| dq_out | output | W | Dividend/quotient register |
| q_out | output | 1 | Current q flag |
| t_out | output | 1 | Current link bit |

## Verification
Single unchained steps are driven with each of the four old-`q`/`m` pairings. The remainders are chosen so that the shift either carries or borrows, or does not, and so that the outgoing top bit is both 0 and 1. This separates the add/subtract choice from the XOR rule for the new `q`. Full 32-step chained runs use small, all-ones and top-bit-set divisors and dividends, and they show that `q` correctly acts as the hidden 33rd remainder bit. Runs with a zero count and with `step_en` held low check the sequencing: a zero count does no work, and a step taken while disabled would corrupt the state.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  // Quotient-sign update: old top bit, adder carry/borrow and divisor sign.
  function automatic logic nrdiv_q_sel(input logic pq, input logic cf, input logic m);
    return pq ^ cf ^ m;
  endfunction

  // Link bit reports agreement between new q and m.
  function automatic logic nrdiv_t_sel(input logic q, input logic m);
    return ~(q ^ m);
  endfunction

endpackage

// File: rtl/nrdiv_step_core.sv
module nrdiv_step_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] dvs,
  input  logic         q_in,
  input  logic         m_in,
  input  logic         t_in,
  output logic [W-1:0] rem_nxt,
  output logic         q_nxt,
  output logic         t_nxt,
  output logic         sub_sel,
  output logic         cf,
  output logic         pq
);
  import nrdiv_pkg::*;

  // W+1 bit add or subtract; top bit is carry-out or borrow.
  function automatic logic [W:0] addsub(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic sub);
    logic [W:0] ax;
    logic [W:0] bx;
    ax = {1'b0, a};
    bx = {1'b0, b};
    return sub ? (ax - bx) : (ax + bx);
  endfunction

  logic [W-1:0] shifted;
  logic [W:0]   sum_ext;

  always_comb begin
    pq      = rem[W-1];
    shifted = {rem[W-2:0], t_in};
    sub_sel = (q_in == m_in);
    sum_ext = addsub(shifted, dvs, sub_sel);
    cf      = sum_ext[W];
    rem_nxt = sum_ext[W-1:0];
    q_nxt   = nrdiv_q_sel(pq, cf, m_in);
    t_nxt   = nrdiv_t_sel(q_nxt, m_in);
  end

endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step_en,
  input  logic [CW-1:0] count,
  output logic          busy,
  output logic          done,
  output logic          fire
);
  logic [CW-1:0] left;

  assign fire = busy & step_en & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      left <= count;
      busy <= (count != '0);
      done <= (count == '0);
    end else if (fire) begin
      left <= left - CW'(1);
      if (left == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nrdiv_state.sv
module nrdiv_state #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         fire,
  input  logic         chain_in,
  input  logic [W-1:0] init_rem,
  input  logic [W-1:0] init_dq,
  input  logic [W-1:0] divisor,
  input  logic         init_q,
  input  logic         init_m,
  input  logic         init_t,
  input  logic [W-1:0] rem_nxt,
  input  logic         q_nxt,
  input  logic         t_nxt,
  output logic [W-1:0] rem,
  output logic [W-1:0] dq,
  output logic [W-1:0] dvs,
  output logic         q,
  output logic         m,
  output logic         t,
  output logic         chain,
  output logic         t_in
);
  assign t_in = chain ? dq[W-1] : t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      dq    <= '0;
      dvs   <= '0;
      q     <= 1'b0;
      m     <= 1'b0;
      t     <= 1'b0;
      chain <= 1'b0;
    end else if (load) begin
      rem   <= init_rem;
      dq    <= init_dq;
      dvs   <= divisor;
      q     <= init_q;
      m     <= init_m;
      t     <= init_t;
      chain <= chain_in;
    end else if (fire) begin
      rem <= rem_nxt;
      q   <= q_nxt;
      t   <= t_nxt;
      if (chain) dq <= {dq[W-2:0], t_nxt};
    end
  end

endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit #(
  parameter int W         = 32,
  parameter int MAX_STEPS = W,
  localparam int CW       = $clog2(MAX_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          chain,
  input  logic          step_en,
  input  logic [CW-1:0] step_count,
  input  logic [W-1:0]  init_rem,
  input  logic [W-1:0]  init_dq,
  input  logic [W-1:0]  divisor,
  input  logic          init_q,
  input  logic          init_m,
  input  logic          init_t,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  rem_out,
  output logic [W-1:0]  dq_out,
  output logic          q_out,
  output logic          t_out
);
  logic          fire;
  logic [W-1:0]  rem_q, dq_q, dvs_q, rem_nxt;
  logic          q_q, m_q, t_q, chain_q, t_in;
  logic          q_nxt, t_nxt, sub_sel, cf, pq;

  nrdiv_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en),
    .count(step_count), .busy(busy), .done(done), .fire(fire)
  );

  nrdiv_state #(.W(W)) u_state (
    .clk(clk), .rst_n(rst_n), .load(start), .fire(fire), .chain_in(chain),
    .init_rem(init_rem), .init_dq(init_dq), .divisor(divisor),
    .init_q(init_q), .init_m(init_m), .init_t(init_t),
    .rem_nxt(rem_nxt), .q_nxt(q_nxt), .t_nxt(t_nxt),
    .rem(rem_q), .dq(dq_q), .dvs(dvs_q), .q(q_q), .m(m_q), .t(t_q),
    .chain(chain_q), .t_in(t_in)
  );

  nrdiv_step_core #(.W(W)) u_core (
    .rem(rem_q), .dvs(dvs_q), .q_in(q_q), .m_in(m_q), .t_in(t_in),
    .rem_nxt(rem_nxt), .q_nxt(q_nxt), .t_nxt(t_nxt),
    .sub_sel(sub_sel), .cf(cf), .pq(pq)
  );

  assign rem_out = rem_q;
  assign dq_out  = dq_q;
  assign q_out   = q_q;
  assign t_out   = t_q;

endmodule

// File: rtl/nrdiv_unit_chk.sv
module nrdiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         step_en,
  input logic         busy,
  input logic         done,
  input logic         fire,
  input logic         sub_sel,
  input logic         cf,
  input logic         pq,
  input logic [W-1:0] rem,
  input logic [W-1:0] dq,
  input logic [W-1:0] dvs,
  input logic         q,
  input logic         m,
  input logic         t,
  input logic         chain
);
  p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_en && !start) |=> ($stable(rem) && $stable(dq) && $stable(q) && $stable(t)));

  p_t_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (t == (q == m)));

  p_q_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (q == ($past(pq) ^ $past(cf) ^ m)));

  p_dq_unchained_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !chain) |=> $stable(dq));

  p_dq_chained_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && chain) |=> (dq == {$past(dq[W-2:0]), t}));

  p_rem_sub_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sub_sel) |=>
      (rem == ({$past(rem[W-2:0]), $past(chain ? dq[W-1] : t)} - dvs)));

  p_rem_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !sub_sel) |=>
      (rem == ({$past(rem[W-2:0]), $past(chain ? dq[W-1] : t)} + dvs)));

endmodule

bind nrdiv_unit nrdiv_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en),
  .busy(busy), .done(done), .fire(fire), .sub_sel(sub_sel), .cf(cf), .pq(pq),
  .rem(rem_q), .dq(dq_q), .dvs(dvs_q), .q(q_q), .m(m_q), .t(t_q), .chain(chain_q)
);

// File: tb/nrdiv_unit_bench.sv
`timescale 1ns/1ps
module nrdiv_unit_bench;
  localparam int W  = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          chain = 1'b0;
  logic          step_en = 1'b1;
  logic [CW-1:0] step_count = '0;
  logic [W-1:0]  init_rem = '0, init_dq = '0, divisor = '0;
  logic          init_q = 1'b0, init_m = 1'b0, init_t = 1'b0;
  logic          busy, done, q_out, t_out;
  logic [W-1:0]  rem_out, dq_out;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  nrdiv_unit u_nrdiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .chain(chain), .step_en(step_en),
    .step_count(step_count), .init_rem(init_rem), .init_dq(init_dq),
    .divisor(divisor), .init_q(init_q), .init_m(init_m), .init_t(init_t),
    .busy(busy), .done(done), .rem_out(rem_out), .dq_out(dq_out),
    .q_out(q_out), .t_out(t_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference step, written as the four-way case table of the requirements.
  function automatic logic [W+1:0] ref_step(input logic [W-1:0] r, input logic [W-1:0] d,
                                            input logic qo, input logic mm, input logic ti);
    logic [W-1:0] sh, res;
    logic [W:0]   wide;
    logic         f, nq, nt;
    sh = {r[W-2:0], ti};
    if (qo == mm) begin
      res = sh - d;
      f   = (sh < d);
    end else begin
      wide = {1'b0, sh} + {1'b0, d};
      res  = wide[W-1:0];
      f    = wide[W];
    end
    case ({r[W-1], mm})
      2'b00:   nq = f;
      2'b10:   nq = ~f;
      2'b01:   nq = ~f;
      default: nq = f;
    endcase
    nt = (nq == mm);
    return {res, nq, nt};
  endfunction

  task automatic kick(input logic ch, input logic [CW-1:0] cnt, input logic [W-1:0] r,
                      input logic [W-1:0] dq, input logic [W-1:0] d,
                      input logic qi, input logic mi, input logic ti);
    @(negedge clk);
    chain = ch; step_count = cnt; init_rem = r; init_dq = dq; divisor = d;
    init_q = qi; init_m = mi; init_t = ti; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 busy", {31'b0, busy}, 32'd0);
    check("R8 done", {31'b0, done}, 32'd0);
    check("R8 rem", rem_out, 32'd0);
    check("R8 dq", dq_out, 32'd0);
    check("R8 q/t", {30'b0, q_out, t_out}, 32'd0);
  endtask

  task automatic t_single(input logic [W-1:0] r, input logic [W-1:0] d,
                          input logic qi, input logic mi, input logic ti);
    logic [W+1:0] e;
    e = ref_step(r, d, qi, mi, ti);
    kick(1'b0, CW'(1), r, 32'hA5A5_0F0F, d, qi, mi, ti);
    @(negedge clk);
    check("R1 rem", rem_out, e[W+1:2]);
    check("R2 q", {31'b0, q_out}, {31'b0, e[1]});
    check("R3 t", {31'b0, t_out}, {31'b0, e[0]});
    check("R6 dq unchained", dq_out, 32'hA5A5_0F0F);
    check("R4 done after 1", {30'b0, busy, done}, 32'd1);
  endtask

  task automatic t_chain_step;
    logic [W+1:0] e;
    e = ref_step(32'h4000_0003, 32'h0000_0005, 1'b0, 1'b0, 1'b1);
    kick(1'b1, CW'(1), 32'h4000_0003, 32'h8000_0002, 32'h5, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R6 chained rem", rem_out, e[W+1:2]);
    check("R6 chained dq", dq_out, {31'h0000_0002, e[0]});
  endtask

  task automatic t_zero;
    kick(1'b0, CW'(0), 32'h1234_5678, 32'h0, 32'h9, 1'b1, 1'b0, 1'b1);
    check("R4 zero count done", {30'b0, busy, done}, 32'd1);
    @(negedge clk);
    check("R4 zero count no step", rem_out, 32'h1234_5678);
  endtask

  task automatic t_hold;
    logic [W+1:0] e;
    logic [W-1:0] r;
    logic         qq, tt;
    step_en = 1'b0;
    kick(1'b0, CW'(3), 32'h0F00_00F1, 32'h0, 32'h0000_0777, 1'b0, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    check("R5 hold rem", rem_out, 32'h0F00_00F1);
    check("R5 hold busy", {30'b0, busy, done}, 32'd2);
    r = 32'h0F00_00F1; qq = 1'b0; tt = 1'b1;
    for (int i = 0; i < 3; i++) begin
      e = ref_step(r, 32'h0000_0777, qq, 1'b1, tt);
      r = e[W+1:2]; qq = e[1]; tt = e[0];
    end
    step_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 three steps done", {30'b0, busy, done}, 32'd1);
    check("R1 three steps rem", rem_out, r);
    check("R2 three steps q", {31'b0, q_out}, {31'b0, qq});
  endtask

  task automatic t_divide(input logic [W-1:0] a, input logic [W-1:0] b, input logic timing);
    int n;
    kick(1'b1, CW'(32), 32'h0, a, b, 1'b0, 1'b0, 1'b0);
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (timing) check("R4 32 steps", n, 32'd32);
    check("R7 quotient", dq_out, a / b);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single(32'h8000_0001, 32'h0000_0003, 1'b0, 1'b0, 1'b1);
    t_single(32'h0000_0001, 32'h0000_0010, 1'b0, 1'b0, 1'b0);
    t_single(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    t_single(32'h0000_0010, 32'h0000_0020, 1'b0, 1'b1, 1'b1);
    t_single(32'hC000_0000, 32'h4000_0000, 1'b1, 1'b1, 1'b0);
    t_single(32'h8000_0000, 32'hFFFF_FFF0, 1'b1, 1'b1, 1'b1);
    t_chain_step();
    t_zero();
    t_hold();
    t_divide(32'd100, 32'd7, 1'b1);
    t_divide(32'hFFFF_FFFF, 32'd1, 1'b0);
    t_divide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    t_divide(32'h1234_5678, 32'h8000_0001, 1'b0);
    t_divide(32'hF234_5678, 32'h8000_0001, 1'b0);
    t_divide(32'd5, 32'd9, 1'b0);
    t_divide(32'hDEAD_BEEF, 32'h0000_1234, 1'b0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule